// File: doc/BRIEF.md
# Memory-Card Slot Status and Interrupt Register Block

This block sits beside a memory-card slot and turns the slot's two status lines into a small register view and one interrupt. The write-protect line is shown live in the status word. A rising card-present condition latches a sticky flag that drives the interrupt output. The flag stays latched until software writes the status word with the clear bit set.

Next to the status word, the block answers three read-only words on the same word-indexed 32-bit register bus: an identification value, a flash-program word and an address-decode word. Each one is a fixed constant chosen by a parameter. Writes to those indices are accepted and have no effect. The card interface itself and any flash programming logic live elsewhere.

Register reads are combinational from the index. Writes and the card-detect input take effect at the next rising clock edge.

Top module: `slot_status_regs`

## Requirements
- R1: While reset is high and in the first cycle after it, the interrupt output is low and bit 3 of the status word (index 2) reads 0.
- R2: Bit 0 of the status word at index 2 reads 1 while the write-protect input is low and 0 while it is high, following the input in the same cycle with no clock edge needed.
- R3: A high level on the card-detect input at a rising clock edge makes status bit 3 read 1 and the interrupt output go high after that edge.
- R4: Once set, status bit 3 and the interrupt output stay high after the card-detect input falls, for as long as no clearing write occurs.
- R5: A write to index 2 whose data has bit 3 set clears status bit 3 and drops the interrupt at the next edge. A write to index 2 with bit 3 of the data clear changes nothing, and the other data bits never have any effect.
- R6: When card-detect is high in the same cycle as a clearing write, the flag stays set and the interrupt stays high.
- R7: Writes to indices 0, 1 and 3, or to any index above 3, leave the flag, the interrupt and all read values unchanged.
- R8: Index 0 reads the ID parameter, index 1 reads the flash-program parameter and index 3 reads the decode parameter. Any index above 3 reads zero, and status bits other than 0 and 3 read zero.
- R9: The interrupt output always equals status bit 3 as read at index 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | IDX_W | Word index of the register being read or written |
| wr_en | input | 1 | Write strobe for the word at reg_idx |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the word at reg_idx (combinational) |
| wprot_in | input | 1 | Write-protect level from the slot (low reads as protected bit set) |
| cdet_in | input | 1 | Card-detect level from the slot (high latches the card flag) |
| card_irq | output | 1 | Card-insertion interrupt, high while the card flag is set |

## Verification
The assertions assume that every input is synchronous to the clock: it changes only away from the rising edge and is stable when sampled. In particular, card-detect and write-protect are taken as already synchronized before they reach the block. The bench follows this by driving all inputs on the falling edge, checking read data one time unit later and checking the interrupt just after the next rising edge. Random index, write, data and slot-line values are mixed with directed sequences for the set-versus-clear collision, writes to the ignored indices and out-of-range reads.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

    localparam int DATA_W   = 32;
    localparam int WP_POS   = 0;   // live write-protect view in status word
    localparam int CARD_POS = 3;   // sticky card flag in status word

    typedef enum logic [1:0] {
        SEL_ID     = 2'd0,
        SEL_FLASH  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_DECODE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;   // index falls inside the four-word window
        reg_sel_e sel;
    } idx_dec_t;

    typedef struct packed {
        logic clear_req;  // status write carrying the clear bit
        logic stat_wr;    // any write to the status word
    } wr_req_t;

    function automatic logic [DATA_W-1:0] status_word(input logic wp_level,
                                                      input logic card_flag);
        logic [DATA_W-1:0] w;
        w           = '0;
        w[WP_POS]   = ~wp_level;
        w[CARD_POS] = card_flag;
        return w;
    endfunction

endpackage

// File: rtl/slot_idx_decode.sv
module slot_idx_decode
    import cdet_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output idx_dec_t          dec,
    output wr_req_t           req
);
    localparam int HI_W = IDX_W - 2;

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

    always_comb begin
        dec.hit = (reg_idx[IDX_W-1:2] == {HI_W{1'b0}});
        dec.sel = reg_sel_e'(reg_idx[1:0]);
        req.stat_wr   = wr_en && dec.hit && (dec.sel == SEL_STATUS);
        req.clear_req = req.stat_wr && wr_data[CARD_POS];
    end

endmodule

// File: rtl/slot_card_flag.sv
module slot_card_flag
    import cdet_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    cdet_in,
    input  wr_req_t req,
    output logic    flag_q
);
    logic flag_d;

    always_comb begin
        flag_d = flag_q;
        if (req.clear_req) flag_d = 1'b0;
        if (cdet_in)       flag_d = 1'b1;   // set wins over clear
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

endmodule

// File: rtl/slot_read_mux.sv
module slot_read_mux
    import cdet_pkg::*;
#(
    parameter logic [31:0] ID_VAL     = 32'h0000_0000,
    parameter logic [31:0] FLASH_VAL  = 32'h0000_0000,
    parameter logic [31:0] DECODE_VAL = 32'h0000_0000
) (
    input  idx_dec_t          dec,
    input  logic              wprot_in,
    input  logic              flag_q,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [4];

    for (genvar g = 0; g < 4; g++) begin : g_word
        if (g == int'(SEL_STATUS)) begin : g_stat
            assign words[g] = status_word(wprot_in, flag_q);
        end else if (g == int'(SEL_ID)) begin : g_id
            assign words[g] = ID_VAL;
        end else if (g == int'(SEL_FLASH)) begin : g_fl
            assign words[g] = FLASH_VAL;
        end else begin : g_dc
            assign words[g] = DECODE_VAL;
        end
    end

    always_comb begin
        rd_data = '0;
        if (dec.hit) rd_data = words[dec.sel];
    end

endmodule

// File: rtl/slot_status_regs.sv
module slot_status_regs
    import cdet_pkg::*;
#(
    parameter int          IDX_W      = 4,
    parameter logic [31:0] ID_VAL     = 32'h4C0D_0310,
    parameter logic [31:0] FLASH_VAL  = 32'h0000_0000,
    parameter logic [31:0] DECODE_VAL = 32'h0000_0011
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic             wprot_in,
    input  logic             cdet_in,
    output logic             card_irq
);
    idx_dec_t dec;
    wr_req_t  req;
    logic     flag_q;

    slot_idx_decode #(.IDX_W(IDX_W)) i_dec (
        .reg_idx (reg_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .dec     (dec),
        .req     (req)
    );

    slot_card_flag i_flag (
        .clk     (clk),
        .rst     (rst),
        .cdet_in (cdet_in),
        .req     (req),
        .flag_q  (flag_q)
    );

    slot_read_mux #(
        .ID_VAL     (ID_VAL),
        .FLASH_VAL  (FLASH_VAL),
        .DECODE_VAL (DECODE_VAL)
    ) i_rd (
        .dec      (dec),
        .wprot_in (wprot_in),
        .flag_q   (flag_q),
        .rd_data  (rd_data)
    );

    assign card_irq = flag_q;

endmodule

// File: rtl/slot_status_chk.sv
module slot_status_chk #(
    parameter int          IDX_W      = 4,
    parameter logic [31:0] ID_VAL     = 32'h0,
    parameter logic [31:0] DECODE_VAL = 32'h0
) (
    input logic             clk,
    input logic             rst,
    input logic [IDX_W-1:0] reg_idx,
    input logic             wr_en,
    input logic [31:0]      wr_data,
    input logic [31:0]      rd_data,
    input logic             wprot_in,
    input logic             cdet_in,
    input logic             card_irq
);
    logic is_stat, clr_wr;
    assign is_stat = (reg_idx == IDX_W'(2));
    assign clr_wr  = wr_en && is_stat && wr_data[3];

    a_r1_reset_low: assert property (@(posedge clk) rst |=> !card_irq);

    a_r2_wp_live: assert property (@(posedge clk) disable iff (rst)
        is_stat |-> (rd_data[0] == !wprot_in));

    a_r3_set: assert property (@(posedge clk) disable iff (rst)
        cdet_in |=> card_irq);

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (card_irq && !clr_wr) |=> card_irq);

    a_r5_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && !cdet_in) |=> !card_irq);

    a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (!card_irq && !cdet_in) |=> !card_irq);

    a_r8_id_read: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == IDX_W'(0)) |-> (rd_data == ID_VAL));

    a_r8_decode_read: assert property (@(posedge clk) disable iff (rst)
        (reg_idx == IDX_W'(3)) |-> (rd_data == DECODE_VAL));

    a_r9_irq_mirror: assert property (@(posedge clk) disable iff (rst)
        is_stat |-> (rd_data[3] == card_irq && rd_data[31:4] == '0 && rd_data[2:1] == '0));

endmodule

bind slot_status_regs slot_status_chk #(
    .IDX_W      (IDX_W),
    .ID_VAL     (ID_VAL),
    .DECODE_VAL (DECODE_VAL)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_idx  (reg_idx),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .wprot_in (wprot_in),
    .cdet_in  (cdet_in),
    .card_irq (card_irq)
);

// File: tb/test_slot_status_regs.sv
module test_slot_status_regs;
    localparam int          IDX_W = 4;
    localparam logic [31:0] P_ID  = 32'hA5C3_0017;
    localparam logic [31:0] P_FL  = 32'h0000_0B0B;
    localparam logic [31:0] P_DC  = 32'h1234_00F0;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IDX_W-1:0] reg_idx = '0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data;
    logic             wprot_in = 1'b1;
    logic             cdet_in = 1'b0;
    logic             card_irq;

    int checks = 0;
    int failures = 0;
    logic exp_flag = 1'b0;

    always #2 clk = ~clk;

    slot_status_regs #(
        .IDX_W(IDX_W), .ID_VAL(P_ID), .FLASH_VAL(P_FL), .DECODE_VAL(P_DC)
    ) i_slot_status_regs (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .wprot_in(wprot_in),
        .cdet_in(cdet_in), .card_irq(card_irq)
    );

    function automatic logic [31:0] exp_read(input logic [IDX_W-1:0] idx,
                                             input logic flag, input logic wp);
        case (idx)
            4'd0:    return P_ID;
            4'd1:    return P_FL;
            4'd2:    return {28'd0, flag, 2'b00, ~wp};
            4'd3:    return P_DC;
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic next_flag(input logic flag, input logic [IDX_W-1:0] idx,
                                       input logic we, input logic [31:0] d,
                                       input logic cd);
        logic f;
        f = flag;
        if (we && idx == 4'd2 && d[3]) f = 1'b0;
        if (cd) f = 1'b1;
        return f;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [IDX_W-1:0] idx, input logic we,
                         input logic [31:0] d, input logic wp, input logic cd,
                         input string rtag, input string itag);
        logic [31:0] er;
        @(negedge clk);
        reg_idx = idx; wr_en = we; wr_data = d; wprot_in = wp; cdet_in = cd;
        #1;
        er = exp_read(idx, exp_flag, wp);
        check(rd_data == er, rtag, rd_data, er);
        exp_flag = next_flag(exp_flag, idx, we, d, cd);
        @(posedge clk);
        #1;
        check(card_irq == exp_flag, itag, {31'd0, card_irq}, {31'd0, exp_flag});
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired (all requirements)");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        check(card_irq == 1'b0, "R1 irq in reset", {31'd0, card_irq}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        // R1: first cycle after reset
        cycle(4'd2, 1'b0, 32'd0, 1'b1, 1'b0, "R1 status after reset", "R1 irq after reset");
        // R2: write-protect live view
        cycle(4'd2, 1'b0, 32'd0, 1'b0, 1'b0, "R2 wp low reads 1", "R2 irq idle");
        cycle(4'd2, 1'b0, 32'd0, 1'b1, 1'b0, "R2 wp high reads 0", "R2 irq idle");
        // R3: set
        cycle(4'd2, 1'b0, 32'd0, 1'b1, 1'b1, "R3 read before set", "R3 irq set");
        // R4: hold after detect falls
        for (int i = 0; i < 4; i++)
            cycle(4'd2, 1'b0, 32'd0, 1'b0, 1'b0, "R4 bit3 held", "R4 irq held");
        // R5: write without bit 3 has no effect
        cycle(4'd2, 1'b1, 32'hFFFF_FFF7, 1'b1, 1'b0, "R5 read", "R5 no clear w/o bit3");
        cycle(4'd2, 1'b0, 32'd0, 1'b1, 1'b0, "R5 status after no-op write", "R5 irq kept");
        // R5: clear
        cycle(4'd2, 1'b1, 32'h0000_0008, 1'b1, 1'b0, "R5 read", "R5 clear");
        cycle(4'd2, 1'b0, 32'd0, 1'b1, 1'b0, "R5 status after clear", "R5 stays clear");
        // R6: collision
        cycle(4'd2, 1'b0, 32'd0, 1'b1, 1'b1, "R6 read", "R6 set");
        cycle(4'd2, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b1, "R6 read", "R6 set wins");
        // R7: writes elsewhere ignored
        cycle(4'd1, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 flash read", "R7 irq kept");
        cycle(4'd3, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 decode read", "R7 irq kept");
        cycle(4'd0, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 id read", "R7 irq kept");
        cycle(4'd10, 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, "R7 high idx", "R7 irq kept");
        cycle(4'd1, 1'b0, 32'd0, 1'b1, 1'b0, "R7 flash after write", "R9 irq");
        cycle(4'd3, 1'b0, 32'd0, 1'b1, 1'b0, "R7 decode after write", "R9 irq");
        cycle(4'd2, 1'b0, 32'd0, 1'b0, 1'b0, "R9 status mirrors irq", "R9 irq");
        // R8: reads
        cycle(4'd0, 1'b0, 32'd0, 1'b1, 1'b0, "R8 id", "R8 irq");
        cycle(4'd15, 1'b0, 32'd0, 1'b1, 1'b0, "R8 out of range", "R8 irq");
        cycle(4'd4, 1'b0, 32'd0, 1'b1, 1'b0, "R8 out of range", "R8 irq");
        // random
        for (int i = 0; i < 3000; i++) begin
            logic [IDX_W-1:0] idx;
            logic we, wp, cd;
            logic [31:0] d;
            string rt, it;
            idx = ($urandom % 4 != 0) ? IDX_W'($urandom % 4) : IDX_W'($urandom);
            we  = ($urandom % 3) == 0;
            d   = $urandom;
            wp  = $urandom % 2;
            cd  = ($urandom % 7) == 0;
            rt  = (idx == 4'd2) ? "R2 random status" : "R8 random read";
            if (cd) it = "R3 random set";
            else if (we && idx == 4'd2 && d[3]) it = "R5 random clear";
            else it = "R4 random hold";
            cycle(idx, we, d, wp, cd, rt, it);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule